// File: doc/BRIEF.md
# Remote Terminal Status Flag Controller

This block produces the four host-controlled flag bits of a serial-bus remote terminal's status word and decides whether the data words of a reply go out or are withheld. The host keeps a four-bit flag register: busy, subsystem fail, bus-control acceptance and terminal flag. It writes the register through a small address/write-enable/data port.

When the command decoder marks a command as valid, the block samples several sources at once. These are the flags, the busy bit from that command's descriptor control word, an external subsystem-fail pin and the other status sources. From them it assembles the full 16-bit status word. In the same cycle it decides whether data words that would normally follow the status must be suppressed.

The status word and the suppress decision are held until the next valid command, so host writes made during a reply cannot disturb it. The block also reports a busy-history flag for the message information word and a matching interrupt-information bit. On a transmit-vector-word mode command it can clear the subsystem-fail register bit by itself.

Top module: `rt_status_ctrl`

## Requirements
- R1: After reset the host flag register reads 0000, the status word is 0x0000, and the suppress, was-busy and interrupt was-busy outputs are 0.
- R2: A host write with the address equal to FLAG_ADDR (default 5) loads host_wdata into the flag register, visible on host_rdata after the next clock edge. The host flag bit positions are: bit 3 busy, bit 2 subsystem fail, bit 1 bus-control acceptance, bit 0 terminal flag. A write to any other address leaves the register unchanged.
- R3: When the host busy bit is 1, status word bit 3 is 1 for every valid command.
- R4: When desc_busy is 1 with a valid command, status bit 3 is 1 for that command only, even with the host busy bit at 0.
- R5: When status carries busy, suppress_data is 1 for a command that would return data words. Such a command has cmd_tx=1 and either a non-mode subaddress or a mode code of 16 or higher. For any other command suppress_data is 0.
- R6: was_busy is 1 after any command answered with busy. irq_was_busy is 1 only when cfg_busy_irq_en is also 1. Busy alone sets no other output.
- R7: Status bit 2 is the OR of the host subsystem-fail bit and the ss_fail_pin input, both sampled with the command.
- R8: A valid command with cmd_tx=1, a mode subaddress (0 or 31) and mode code 16, while cfg_mc_opt=0, clears the host subsystem-fail bit. The status word of that same command already shows the register contribution as 0. With cfg_mc_opt=1 the bit is kept.
- R9: When a host write and the automatic subsystem-fail clear fall in the same cycle, the subsystem-fail bit ends at 0 and the other three bits take the written values.
- R10: Status bit 1 equals the host bus-control acceptance bit, and status bit 0 equals the host terminal-flag bit.
- R11: The terminal flag sets suppress_data for transmit commands to a data subaddress and for transmit mode codes 16 to 31. It does not set it for receive commands or mode codes below 16.
- R12: The status word is laid out as follows: term_addr in bits 15:11, stat_msg_err in bit 10, stat_instr in bit 9, stat_srq in bit 8, zeros in bits 7:5 and stat_bcast in bit 4. All outputs stay unchanged between valid commands, whatever the host writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 4 | Host write data (busy, subsystem fail, acceptance, terminal flag) |
| host_rdata | output | 4 | Current host flag register |
| ss_fail_pin | input | 1 | External subsystem-fail input |
| cfg_mc_opt | input | 1 | 0 enables the automatic subsystem-fail clear on mode code 16 |
| cfg_busy_irq_en | input | 1 | Enables the was-busy interrupt information bit |
| cmd_valid | input | 1 | One-cycle strobe for a decoded valid command |
| cmd_tx | input | 1 | Command direction, 1 = terminal transmits |
| cmd_subaddr | input | 5 | Command subaddress / mode field |
| cmd_code | input | 5 | Word count or mode code |
| desc_busy | input | 1 | Busy bit from the command's descriptor control word |
| term_addr | input | 5 | Terminal address for the status word |
| stat_msg_err | input | 1 | Message error source |
| stat_instr | input | 1 | Instrumentation source |
| stat_srq | input | 1 | Service request source |
| stat_bcast | input | 1 | Broadcast received source |
| status_word | output | 16 | Held status word |
| suppress_data | output | 1 | 1 = withhold the data words of the reply |
| was_busy | output | 1 | Busy-history flag for the message information word |
| irq_was_busy | output | 1 | Was-busy bit for the interrupt information word |

## Verification
Every output is registered on the command strobe. A wrong flag, busy source or subsystem-fail term therefore shows in the status word and suppress_data on the clock edge that ends the command cycle, one cycle after the strobe. A register that misses the automatic clear, or lets a host write win over it, shows on host_rdata on that same edge. It also shows in bit 2 of the next status word. A hold path that reloads without a strobe shows as a status word that changes after a host write, with no command in between.

// File: rtl/rtsf_pkg.sv
package rtsf_pkg;
  localparam int unsigned TA_W   = 5;
  localparam int unsigned FLAG_W = 4;

  typedef struct packed {
    logic busy;
    logic ssf;
    logic dbca;
    logic tf;
  } host_flags_t;

  typedef struct packed {
    logic [TA_W-1:0] rt_addr;
    logic            msg_err;
    logic            instr;
    logic            srq;
    logic [2:0]      rsvd;
    logic            bcast;
    logic            busy;
    logic            ssf;
    logic            dbca;
    logic            tf;
  } status_word_t;
endpackage

// File: rtl/rtsf_host_flags.sv
module rtsf_host_flags
  import rtsf_pkg::*;
#(
  parameter int unsigned           ADDR_W    = 4,
  parameter logic [ADDR_W-1:0]     FLAG_ADDR = 'h5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  host_flags_t       wdata,
  input  logic              clr_ssf,
  output host_flags_t       flags_q
);
  logic        hit;
  logic        flags_en;
  host_flags_t flags_d;

  always_comb begin
    hit      = wr_en && (addr == FLAG_ADDR);
    flags_en = hit || clr_ssf;
    flags_d  = flags_q;
    if (hit)     flags_d     = wdata;
    if (clr_ssf) flags_d.ssf = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  // R9 / R8: automatic clear beats any simultaneous host write
  assert_autoclr_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ssf |=> !flags_q.ssf);

  // R2: register holds when neither a matching write nor a clear occurs
  assert_flags_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !clr_ssf) |=> $stable(flags_q));
endmodule

// File: rtl/rtsf_cmd_decode.sv
module rtsf_cmd_decode #(
  parameter int unsigned SA_W      = 5,
  parameter int unsigned CODE_W    = 5,
  parameter int unsigned VEC_CODE  = 16,
  parameter bit          SA_HI_MODE = 1'b1
) (
  input  logic              tx,
  input  logic [SA_W-1:0]   subaddr,
  input  logic [CODE_W-1:0] code,
  output logic              is_mode,
  output logic              data_expected,
  output logic              is_vec_word
);
  localparam logic [CODE_W-1:0] VEC_VAL = CODE_W'(VEC_CODE);

  generate
    if (SA_HI_MODE) begin : g_two_mode_sa
      assign is_mode = (subaddr == '0) || (subaddr == '1);
    end else begin : g_one_mode_sa
      assign is_mode = (subaddr == '0);
    end
  endgenerate

  // upper half of the mode-code space carries a data word on transmit
  assign data_expected = tx && (!is_mode || code[CODE_W-1]);
  assign is_vec_word   = tx && is_mode && (code == VEC_VAL);

  // R8: the vector-word command is always a data-bearing transmit
  always_comb begin
    if (is_vec_word) assert_vec_has_data_R8: assert (data_expected);
  end
endmodule

// File: rtl/rtsf_status_latch.sv
module rtsf_status_latch
  import rtsf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  host_flags_t     flags,
  input  logic            desc_busy,
  input  logic            ss_pin,
  input  logic            ssf_clearing,
  input  logic            data_expected,
  input  logic            busy_irq_en,
  input  logic [TA_W-1:0] term_addr,
  input  logic            msg_err,
  input  logic            instr,
  input  logic            srq,
  input  logic            bcast,
  output status_word_t    status_q,
  output logic            suppress_q,
  output logic            was_busy_q,
  output logic            irq_wb_q
);
  status_word_t status_d;
  logic         busy_now;
  logic         suppress_d;
  logic         irq_wb_d;

  always_comb begin
    busy_now         = flags.busy || desc_busy;
    status_d         = '0;
    status_d.rt_addr = term_addr;
    status_d.msg_err = msg_err;
    status_d.instr   = instr;
    status_d.srq     = srq;
    status_d.bcast   = bcast;
    status_d.busy    = busy_now;
    status_d.ssf     = ss_pin || (flags.ssf && !ssf_clearing);
    status_d.dbca    = flags.dbca;
    status_d.tf      = flags.tf;
    suppress_d       = data_expected && (busy_now || flags.tf);
    irq_wb_d         = busy_now && busy_irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q   <= '0;
      suppress_q <= 1'b0;
      was_busy_q <= 1'b0;
      irq_wb_q   <= 1'b0;
    end else if (cmd_valid) begin
      status_q   <= status_d;
      suppress_q <= suppress_d;
      was_busy_q <= busy_now;
      irq_wb_q   <= irq_wb_d;
    end
  end

  assert_global_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && flags.busy) |=> status_q.busy);

  assert_no_data_no_suppress_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !data_expected) |=> !suppress_q);

  assert_irq_needs_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_wb_q |-> was_busy_q);

  assert_pin_forces_ssf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && ss_pin) |=> status_q.ssf);

  assert_status_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(status_q) && $stable(suppress_q)));
endmodule

// File: rtl/rt_status_ctrl.sv
module rt_status_ctrl
  import rtsf_pkg::*;
#(
  parameter int unsigned           ADDR_W    = 4,
  parameter logic [ADDR_W-1:0]     FLAG_ADDR = 'h5,
  parameter int unsigned           SA_W      = 5,
  parameter int unsigned           CODE_W    = 5,
  parameter int unsigned           VEC_CODE  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [FLAG_W-1:0] host_wdata,
  output logic [FLAG_W-1:0] host_rdata,
  input  logic              ss_fail_pin,
  input  logic              cfg_mc_opt,
  input  logic              cfg_busy_irq_en,
  input  logic              cmd_valid,
  input  logic              cmd_tx,
  input  logic [SA_W-1:0]   cmd_subaddr,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              desc_busy,
  input  logic [TA_W-1:0]   term_addr,
  input  logic              stat_msg_err,
  input  logic              stat_instr,
  input  logic              stat_srq,
  input  logic              stat_bcast,
  output logic [15:0]       status_word,
  output logic              suppress_data,
  output logic              was_busy,
  output logic              irq_was_busy
);
  host_flags_t  flags_q;
  status_word_t status_q;
  logic         is_mode;
  logic         data_expected;
  logic         is_vec_word;
  logic         clr_ssf;

  assign clr_ssf = cmd_valid && is_vec_word && !cfg_mc_opt;

  rtsf_cmd_decode #(
    .SA_W(SA_W), .CODE_W(CODE_W), .VEC_CODE(VEC_CODE), .SA_HI_MODE(1'b1)
  ) u_decode (
    .tx(cmd_tx), .subaddr(cmd_subaddr), .code(cmd_code),
    .is_mode(is_mode), .data_expected(data_expected), .is_vec_word(is_vec_word)
  );

  rtsf_host_flags #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)) u_flags (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr_en), .addr(host_addr),
    .wdata(host_flags_t'(host_wdata)), .clr_ssf(clr_ssf), .flags_q(flags_q)
  );

  rtsf_status_latch u_latch (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .flags(flags_q),
    .desc_busy(desc_busy), .ss_pin(ss_fail_pin), .ssf_clearing(clr_ssf),
    .data_expected(data_expected), .busy_irq_en(cfg_busy_irq_en),
    .term_addr(term_addr), .msg_err(stat_msg_err), .instr(stat_instr),
    .srq(stat_srq), .bcast(stat_bcast), .status_q(status_q),
    .suppress_q(suppress_data), .was_busy_q(was_busy), .irq_wb_q(irq_was_busy)
  );

  assign host_rdata  = flags_q;
  assign status_word = status_q;

  // R11: a mode code below the data half never gets its data suppressed
  assert_low_mode_no_suppress_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && is_mode && !cmd_code[CODE_W-1]) |=> !suppress_data);
endmodule

// File: tb/rt_status_ctrl_tb.sv
module rt_status_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] FADDR = 4'h5;
  localparam logic [4:0] TA = 5'h0A;

  typedef struct packed {
    logic [3:0] flags; logic pin; logic dbusy; logic opt; logic irqen;
    logic tx; logic [4:0] sa; logic [4:0] code;
    logic [3:0] nib; logic sup; logic wb; logic irq; logic [3:0] after;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{4'b0000,1'b0,1'b0,1'b1,1'b0,1'b1,5'd3,5'd2,  4'b0000,1'b0,1'b0,1'b0,4'b0000},
    '{4'b1000,1'b0,1'b0,1'b1,1'b0,1'b0,5'd3,5'd2,  4'b1000,1'b0,1'b1,1'b0,4'b1000},
    '{4'b1000,1'b0,1'b0,1'b1,1'b1,1'b1,5'd3,5'd2,  4'b1000,1'b1,1'b1,1'b1,4'b1000},
    '{4'b0000,1'b0,1'b1,1'b1,1'b0,1'b1,5'd3,5'd2,  4'b1000,1'b1,1'b1,1'b0,4'b0000},
    '{4'b0000,1'b0,1'b0,1'b1,1'b0,1'b1,5'd3,5'd2,  4'b0000,1'b0,1'b0,1'b0,4'b0000},
    '{4'b0100,1'b0,1'b0,1'b1,1'b0,1'b1,5'd0,5'd16, 4'b0100,1'b0,1'b0,1'b0,4'b0100},
    '{4'b0100,1'b0,1'b0,1'b0,1'b0,1'b1,5'd0,5'd16, 4'b0000,1'b0,1'b0,1'b0,4'b0000},
    '{4'b0100,1'b1,1'b0,1'b0,1'b0,1'b1,5'd0,5'd16, 4'b0100,1'b0,1'b0,1'b0,4'b0000},
    '{4'b0000,1'b1,1'b0,1'b1,1'b0,1'b0,5'd3,5'd2,  4'b0100,1'b0,1'b0,1'b0,4'b0000},
    '{4'b0010,1'b0,1'b0,1'b1,1'b0,1'b0,5'd3,5'd2,  4'b0010,1'b0,1'b0,1'b0,4'b0010},
    '{4'b0001,1'b0,1'b0,1'b1,1'b0,1'b1,5'd3,5'd2,  4'b0001,1'b1,1'b0,1'b0,4'b0001},
    '{4'b0001,1'b0,1'b0,1'b1,1'b0,1'b0,5'd3,5'd2,  4'b0001,1'b0,1'b0,1'b0,4'b0001},
    '{4'b0001,1'b0,1'b0,1'b1,1'b0,1'b1,5'd31,5'd2, 4'b0001,1'b0,1'b0,1'b0,4'b0001},
    '{4'b0001,1'b0,1'b0,1'b1,1'b0,1'b1,5'd0,5'd16, 4'b0001,1'b1,1'b0,1'b0,4'b0001},
    '{4'b0001,1'b0,1'b0,1'b1,1'b0,1'b0,5'd0,5'd17, 4'b0001,1'b0,1'b0,1'b0,4'b0001},
    '{4'b0101,1'b0,1'b0,1'b0,1'b0,1'b1,5'd0,5'd16, 4'b0001,1'b1,1'b0,1'b0,4'b0001},
    '{4'b1000,1'b0,1'b0,1'b1,1'b0,1'b1,5'd31,5'd2, 4'b1000,1'b0,1'b1,1'b0,4'b1000}
  };

  function automatic string vtag(int i);
    case (i)
      0, 4:        return "R4";
      1:           return "R6";
      2:           return "R3";
      3:           return "R5";
      5, 6:        return "R8";
      7, 8:        return "R7";
      9:           return "R10";
      10, 11, 12, 13, 14: return "R11";
      default:     return "R5";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst_n;
  logic host_wr_en; logic [3:0] host_addr; logic [3:0] host_wdata; logic [3:0] host_rdata;
  logic ss_fail_pin, cfg_mc_opt, cfg_busy_irq_en, cmd_valid, cmd_tx, desc_busy;
  logic [4:0] cmd_subaddr, cmd_code, term_addr;
  logic stat_msg_err, stat_instr, stat_srq, stat_bcast;
  logic [15:0] status_word;
  logic suppress_data, was_busy, irq_was_busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rt_status_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .ss_fail_pin(ss_fail_pin),
    .cfg_mc_opt(cfg_mc_opt), .cfg_busy_irq_en(cfg_busy_irq_en), .cmd_valid(cmd_valid),
    .cmd_tx(cmd_tx), .cmd_subaddr(cmd_subaddr), .cmd_code(cmd_code),
    .desc_busy(desc_busy), .term_addr(term_addr), .stat_msg_err(stat_msg_err),
    .stat_instr(stat_instr), .stat_srq(stat_srq), .stat_bcast(stat_bcast),
    .status_word(status_word), .suppress_data(suppress_data),
    .was_busy(was_busy), .irq_was_busy(irq_was_busy)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic write_flags(logic [3:0] addr, logic [3:0] data);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = addr; host_wdata = data;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  // drives a command for one cycle; returns at the negedge after its capture
  task automatic issue_cmd(logic tx, logic [4:0] sa, logic [4:0] code, logic db);
    cmd_valid = 1'b1; cmd_tx = tx; cmd_subaddr = sa; cmd_code = code; desc_busy = db;
    @(negedge clk);
    cmd_valid = 1'b0; desc_busy = 1'b0;
  endtask

  function automatic logic [15:0] exp_sw(logic [3:0] nib, logic me, logic in, logic sr, logic bc);
    return {TA, me, in, sr, 3'b000, bc, nib};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_wr_en = 1'b0; host_addr = '0; host_wdata = '0;
    ss_fail_pin = 1'b0; cfg_mc_opt = 1'b1; cfg_busy_irq_en = 1'b0;
    cmd_valid = 1'b0; cmd_tx = 1'b0; cmd_subaddr = '0; cmd_code = '0; desc_busy = 1'b0;
    term_addr = TA; stat_msg_err = 1'b0; stat_instr = 1'b0; stat_srq = 1'b0; stat_bcast = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 flags", {12'h0, host_rdata}, 16'h0);
    check("R1 status", status_word, 16'h0);
    check("R1 outs", {13'h0, suppress_data, was_busy, irq_was_busy}, 16'h0);

    // R2 address decode
    write_flags(FADDR + 4'd1, 4'b1111);
    check("R2 other address ignored", {12'h0, host_rdata}, 16'h0);
    write_flags(FADDR, 4'b1010);
    check("R2 write", {12'h0, host_rdata}, 16'h000A);

    // table of vectors
    for (int i = 0; i < NV; i++) begin
      write_flags(FADDR, VEC[i].flags);
      ss_fail_pin = VEC[i].pin; cfg_mc_opt = VEC[i].opt; cfg_busy_irq_en = VEC[i].irqen;
      issue_cmd(VEC[i].tx, VEC[i].sa, VEC[i].code, VEC[i].dbusy);
      check($sformatf("%s vec%0d status", vtag(i), i), status_word, exp_sw(VEC[i].nib, 1'b0, 1'b0, 1'b0, 1'b0));
      check($sformatf("%s vec%0d suppress", vtag(i), i), {15'h0, suppress_data}, {15'h0, VEC[i].sup});
      check($sformatf("%s vec%0d busy hist", vtag(i), i), {14'h0, was_busy, irq_was_busy}, {14'h0, VEC[i].wb, VEC[i].irq});
      check($sformatf("%s vec%0d flags", vtag(i), i), {12'h0, host_rdata}, {12'h0, VEC[i].after});
      ss_fail_pin = 1'b0;
    end

    // R12 other status sources and layout
    stat_msg_err = 1'b1; stat_srq = 1'b1; stat_bcast = 1'b1;
    write_flags(FADDR, 4'b0010);
    cfg_mc_opt = 1'b1;
    issue_cmd(1'b0, 5'd3, 5'd2, 1'b0);
    check("R12 layout", status_word, exp_sw(4'b0010, 1'b1, 1'b0, 1'b1, 1'b1));
    stat_msg_err = 1'b0; stat_srq = 1'b0; stat_bcast = 1'b0; stat_instr = 1'b1;

    // R12 hold: host writes and pin changes between commands leave outputs alone
    write_flags(FADDR, 4'b1101);
    ss_fail_pin = 1'b1;
    @(negedge clk);
    check("R12 hold status", status_word, exp_sw(4'b0010, 1'b1, 1'b0, 1'b1, 1'b1));
    check("R12 hold suppress", {14'h0, suppress_data, was_busy}, 16'h0);
    ss_fail_pin = 1'b0; stat_instr = 1'b0;

    // R9 collision: write and auto-clear in one cycle
    write_flags(FADDR, 4'b0100);
    cfg_mc_opt = 1'b0;
    host_wr_en = 1'b1; host_addr = FADDR; host_wdata = 4'b0111;
    issue_cmd(1'b1, 5'd0, 5'd16, 1'b0);
    host_wr_en = 1'b0;
    check("R9 clear wins", {12'h0, host_rdata}, 16'h0003);
    check("R9 status", status_word, exp_sw(4'b0000, 1'b0, 1'b0, 1'b0, 1'b0));

    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rereset", {12'h0, host_rdata}, 16'h0);
    check("R1 rereset status", status_word, 16'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule